// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Front End

This block is the digital register front end of a four-channel, 12-bit converter. A host reaches it over a small parallel bus. The bus carries a 2-bit channel address, a read/write select, an active-low chip select, an active-low load strobe and an active-low reset. The 12-bit bidirectional data bus is split into a data-in word, a data-out word and an output-enable. Each channel holds two ranks of registers. The first rank takes host writes and can be read back. The second rank drives the converter code outputs, which are concatenated on `dac_code`.

The host first stages new codes in the first rank, one channel per write. It then pulls the load strobe low, and all four second-rank registers take their new codes on the same clock edge. The load strobe is asynchronous to the system clock, so it passes through a two-flop synchronizer. A load state machine then qualifies it against a minimum pulse width of `LOAD_MIN` clock cycles.

The machine has three states. `LD_IDLE` waits for a qualified low. `LD_COUNT` counts the consecutive qualified cycles. `LD_ACTIVE` makes the second rank transparent.
- `LD_IDLE` goes to `LD_COUNT` on a qualified low. It goes straight to `LD_ACTIVE` when `LOAD_MIN` is 1.
- `LD_COUNT` goes to `LD_ACTIVE` when the count reaches `LOAD_MIN`.
- `LD_COUNT` and `LD_ACTIVE` both fall back to `LD_IDLE` as soon as the synchronized strobe is high or chip select is high.

The reset is asynchronous and does not depend on chip select. It returns every register to center code, or to zero code when `ZERO_RESET` is set.

Top module: `quad_dac_regs`

## Requirements
- R1: Address code 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k occupies `dac_code[12k+11:12k]`. Data bit 11 is the MSB and the coding is straight binary.
- R2: While `cs_n` is high, no first-rank register changes. In that state `dout_oe` is 0 and `dout` is 0.
- R3: On a clock edge where `cs_n` is 0 and `rw` is 0, `din` is stored in the addressed first-rank register. The other three channels keep their values.
- R4: While `cs_n` is 0 and `rw` is 1, `dout_oe` is 1 and `dout` shows the addressed first-rank register. Otherwise `dout_oe` is 0.
- R5: `dac_code` does not change on an edge where the load state machine is not in `LD_ACTIVE`.
- R6: `ld_n` passes two synchronizer flops. After `LOAD_MIN` consecutive edges that see the synchronized strobe low with `cs_n` low, the machine is in `LD_ACTIVE`. On every later edge it stays there, and all four second-rank registers take their first-rank values on that edge.
- R7: A write made on an edge where the machine is in `LD_ACTIVE` reaches the addressed channel of `dac_code` on that same edge.
- R8: A synchronized low shorter than `LOAD_MIN` cycles, or any low held while `cs_n` is high, leaves `dac_code` unchanged.
- R9: With `rst_n` low, whatever `cs_n` is, every register holds 0x800 at once. With `ZERO_RESET` = 1 the value is 0x000 instead. Reset overrides any bus operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read back, 0 = write |
| ld_n | input | 1 | Active-low global load strobe, asynchronous |
| addr | input | 2 | Channel address |
| din | input | 12 | Write data |
| dout | output | 12 | Readback data, 0 when not driven |
| dout_oe | output | 1 | Drive enable for the shared data bus |
| dac_code | output | 48 | Second-rank codes, channel A in the low bits |

## Verification
The bench builds two copies of the block that share the same stimulus. The first uses `LOAD_MIN` = 3 with a center-code reset. This makes short strobes that stop in `LD_COUNT` observable and shows that they are rejected. The second uses `LOAD_MIN` = 1 with a zero-code reset. There, the same short strobe does reach `LD_ACTIVE`, and the zero reset value can be seen on the outputs. Flow-through writes, deselected strobes and a reset in mid-run are compared against a behavioural model for both copies.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_COUNT  = 2'd1,
        LD_ACTIVE = 2'd2
    } ld_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_load_fsm.sv
module qdac_load_fsm
    import qdac_pkg::*;
#(
    parameter int unsigned LOAD_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_low_s,
    input  logic cs_act,
    output logic load_en,
    output ld_state_e state
);
    localparam int unsigned CW = cnt_width(LOAD_MIN);
    localparam logic [CW-1:0] CNT_LAST = CW'(LOAD_MIN - 1);

    ld_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          qual;

    assign qual = ld_low_s && cs_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LD_IDLE: begin
                if (qual) begin
                    state_d = (LOAD_MIN <= 1) ? LD_ACTIVE : LD_COUNT;
                    cnt_d   = CW'(1);
                end
            end
            LD_COUNT: begin
                if (!qual) begin
                    state_d = LD_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = LD_ACTIVE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            LD_ACTIVE: begin
                if (!qual) begin
                    state_d = LD_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = LD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_en = (state_q == LD_ACTIVE);
        state   = state_q;
    end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned ADDR_W = 2,
    parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     load_en,
    output logic [NUM_CH*DATA_W-1:0] in_flat,
    output logic [NUM_CH*DATA_W-1:0] out_flat,
    output logic [DATA_W-1:0]        rd_data
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            logic              hit;
            logic [DATA_W-1:0] in_q, in_d, out_q;

            assign hit  = wr_en && (addr == ADDR_W'(g));
            assign in_d = hit ? wr_data : in_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    in_q  <= RESET_CODE;
                    out_q <= RESET_CODE;
                end else begin
                    in_q <= in_d;
                    if (load_en) begin
                        out_q <= in_d;
                    end
                end
            end

            assign in_flat[g*DATA_W +: DATA_W]  = in_q;
            assign out_flat[g*DATA_W +: DATA_W] = out_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_data = in_flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import qdac_pkg::*;
#(
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned LOAD_MIN   = 3,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter bit          ZERO_RESET = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       rw,
    input  logic                       ld_n,
    input  logic [$clog2(NUM_CH)-1:0]  addr,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic                       dout_oe,
    output logic [NUM_CH*DATA_W-1:0]   dac_code
);
    localparam int unsigned ADDR_W = $clog2(NUM_CH);
    localparam logic [DATA_W-1:0] RESET_CODE =
        ZERO_RESET ? '0 : {1'b1, {(DATA_W-1){1'b0}}};

    logic                     ld_n_s;
    logic                     load_en;
    ld_state_e                ld_state;
    logic                     wr_en, rd_en;
    logic [DATA_W-1:0]        rd_data;
    logic [NUM_CH*DATA_W-1:0] in_flat;

    qdac_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_ld_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ld_n),
        .q_sync  (ld_n_s)
    );

    qdac_load_fsm #(.LOAD_MIN(LOAD_MIN)) u_load_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_low_s (!ld_n_s),
        .cs_act   (!cs_n),
        .load_en  (load_en),
        .state    (ld_state)
    );

    assign wr_en = !cs_n && !rw;
    assign rd_en = !cs_n && rw;

    qdac_bank #(
        .NUM_CH     (NUM_CH),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .RESET_CODE (RESET_CODE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (din),
        .load_en  (load_en),
        .in_flat  (in_flat),
        .out_flat (dac_code),
        .rd_data  (rd_data)
    );

    assign dout_oe = rd_en;
    assign dout    = rd_en ? rd_data : '0;
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned DATA_W     = 12,
    parameter bit          ZERO_RESET = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     rw,
    input logic                     dout_oe,
    input logic [DATA_W-1:0]        dout,
    input logic [NUM_CH*DATA_W-1:0] dac_code,
    input logic [NUM_CH*DATA_W-1:0] in_flat,
    input logic                     load_en
);
    localparam logic [DATA_W-1:0] RST_CODE =
        ZERO_RESET ? '0 : {1'b1, {(DATA_W-1){1'b0}}};

    assert_oe_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!cs_n && rw));

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dout_oe && dout == '0));

    assert_first_rank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(in_flat));

    assert_second_rank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(dac_code));

    assert_load_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(!cs_n));

    assert_reset_code_R9: assert property (@(posedge clk)
        !rst_n |-> (dac_code == {NUM_CH{RST_CODE}} && in_flat == {NUM_CH{RST_CODE}}));
endmodule

bind quad_dac_regs qdac_checker #(
    .NUM_CH     (NUM_CH),
    .DATA_W     (DATA_W),
    .ZERO_RESET (ZERO_RESET)
) u_qdac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rw       (rw),
    .dout_oe  (dout_oe),
    .dout     (dout),
    .dac_code (dac_code),
    .in_flat  (in_flat),
    .load_en  (load_en)
);

// File: tb/quad_dac_regs_bench.sv
`timescale 1ns/1ps
module quad_dac_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rw = 1'b1;
    logic        ld_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [11:0] din = 12'h000;

    logic [11:0] dout0, dout1;
    logic        oe0, oe1;
    logic [47:0] code0, code1;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string phase = "R9 reset";

    always #2 clk = ~clk;

    quad_dac_regs #(.LOAD_MIN(3), .ZERO_RESET(1'b0)) u_quad_dac_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n),
        .addr(addr), .din(din), .dout(dout0), .dout_oe(oe0), .dac_code(code0)
    );

    quad_dac_regs #(.LOAD_MIN(1), .ZERO_RESET(1'b1)) u_quad_dac_regs_zero (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n),
        .addr(addr), .din(din), .dout(dout1), .dout_oe(oe1), .dac_code(code1)
    );

    // behavioural reference model, one slot per instance
    logic [11:0] m_in  [2][4];
    logic [11:0] m_out [2][4];
    int          m_run [2];
    bit          m_act [2];
    bit          m_s1  [2];
    bit          m_s2  [2];
    int          lmin  [2] = '{3, 1};
    logic [11:0] rcode [2] = '{12'h800, 12'h000};

    always @(posedge clk or negedge rst_n) begin
        for (int j = 0; j < 2; j++) begin
            if (!rst_n) begin
                for (int i = 0; i < 4; i++) begin
                    m_in[j][i]  = rcode[j];
                    m_out[j][i] = rcode[j];
                end
                m_run[j] = 0; m_act[j] = 0; m_s1[j] = 1; m_s2[j] = 1;
            end else begin
                bit qual;
                qual = !m_s2[j] && !cs_n;
                if (!cs_n && !rw) m_in[j][addr] = din;
                if (m_act[j]) for (int i = 0; i < 4; i++) m_out[j][i] = m_in[j][i];
                m_run[j] = qual ? m_run[j] + 1 : 0;
                m_act[j] = (m_run[j] >= lmin[j]);
                m_s2[j] = m_s1[j];
                m_s1[j] = ld_n;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic compare_all();
        for (int j = 0; j < 2; j++) begin
            logic [47:0] e_code, g_code;
            logic [11:0] e_dout, g_dout;
            logic        e_oe, g_oe;
            for (int i = 0; i < 4; i++) e_code[i*12 +: 12] = m_out[j][i];
            e_oe   = !cs_n && rw;
            e_dout = e_oe ? m_in[j][addr] : 12'h000;
            g_code = (j == 0) ? code0 : code1;
            g_dout = (j == 0) ? dout0 : dout1;
            g_oe   = (j == 0) ? oe0 : oe1;
            checks++;
            if (g_code !== e_code || g_dout !== e_dout || g_oe !== e_oe) begin
                errors++;
                $display("FAIL %s inst%0d: code %h exp %h, dout %h exp %h, oe %b exp %b",
                         phase, j, g_code, e_code, g_dout, e_dout, g_oe, e_oe);
            end
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    logic [11:0] vals [4] = '{12'h123, 12'h456, 12'h789, 12'hABC};

    initial begin
        #1 rst_n = 1'b0;
        step(2);
        chk("R9 center reset", code0, {4{12'h800}});
        chk("R9 zero reset", code1, 48'h0);
        rst_n = 1'b1;
        step(2);

        phase = "R3 write, R5 no load";
        for (int i = 0; i < 4; i++) begin
            cs_n = 0; rw = 0; addr = 2'(i); din = vals[i];
            step(1);
        end
        cs_n = 1; rw = 1;
        step(1);
        chk("R5 outputs held after writes", code0, {4{12'h800}});

        phase = "R4 readback, R1 mapping";
        for (int i = 0; i < 4; i++) begin
            cs_n = 0; rw = 1; addr = 2'(i);
            step(1);
            chk("R4 readback", {36'h0, dout0}, {36'h0, vals[i]});
        end

        phase = "R2 deselected write";
        cs_n = 1; rw = 0; din = 12'hFFF;
        for (int i = 0; i < 4; i++) begin
            addr = 2'(i);
            step(1);
        end
        cs_n = 0; rw = 1; addr = 2'd3;
        step(1);
        chk("R2 no write while deselected", {36'h0, dout0}, {36'h0, 12'hABC});

        phase = "R8 short load";
        ld_n = 0;
        step(2);
        ld_n = 1;
        step(4);
        chk("R8 short strobe ignored", code0, {4{12'h800}});

        phase = "R6 global load";
        ld_n = 0;
        step(6);
        ld_n = 1;
        step(4);
        chk("R6 R1 channel codes", code0, {vals[3], vals[2], vals[1], vals[0]});

        phase = "R7 flow-through";
        ld_n = 0;
        step(6);
        rw = 0; addr = 2'd2; din = 12'hFFF;
        step(1);
        chk("R7 channel C same edge", {36'h0, code0[35:24]}, {36'h0, 12'hFFF});
        addr = 2'd0; din = 12'h000;
        step(1);
        chk("R7 channel A same edge", {36'h0, code0[11:0]}, 48'h0);
        rw = 1; ld_n = 1;
        step(4);

        phase = "R8 deselected load";
        cs_n = 0; rw = 0; addr = 2'd1; din = 12'h5A5;
        step(1);
        cs_n = 1; rw = 1; ld_n = 0;
        step(6);
        chk("R8 load with cs high ignored", {36'h0, code0[23:12]}, {36'h0, 12'h456});
        ld_n = 1;
        step(3);

        phase = "R9 reset mid-run";
        cs_n = 0; rw = 0; addr = 2'd1; din = 12'h777;
        rst_n = 0;
        step(2);
        chk("R9 reset overrides write", code0, {4{12'h800}});
        chk("R9 zero reset mid-run", code1, 48'h0);
        cs_n = 1; rw = 1;
        rst_n = 1;
        step(2);

        summary();
        $finish;
    end
endmodule